// File: doc/BRIEF.md
# Serial Configuration Loader for a Pulse Generator

This block receives setup bytes for a pulse-width generator over a write-only three-wire serial port. The port has an active-low select, a serial clock that idles low, and a data line. All three pins are brought into the system clock domain through multi-flop synchronizers. Edges of select and of the serial clock are then detected there. While the port is selected, each rising serial-clock edge shifts one data bit into a 24-bit chain, most significant bit first.

When select is released, the number of bits received decides which of the three 8-bit registers (control, frequency and pulse-width) take new values. The update is made only at that point and never byte by byte. A frame of 24 bits loads all three registers. A frame of 16 bits loads frequency and pulse-width. A frame of 8 bits loads pulse-width alone. Any other count is dropped. Each update raises a one-cycle write strobe, which the pulse generator uses to clear a latched fault. A sticky flag reports that a full 24-bit load has taken place since reset.

The control logic is a three-state machine:
- `ST_IDLE` moves to `ST_SHIFT` on a falling edge of select.
- `ST_SHIFT` moves to `ST_COMMIT` on a rising edge of select.
- `ST_COMMIT` returns to `ST_IDLE` after one cycle.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, all three registers read 0, `init_done` is 0 and `wr_pulse` is 0.
- R2: A bit is taken on each rising edge of `sclk` while `sel_n` is low, most significant bit first. The last bit received is bit 0 of the last byte.
- R3: A frame of exactly 24 bits loads `ctrl_q` from the first byte, `freq_q` from the second byte and `width_q` from the third byte.
- R4: A frame of exactly 16 bits loads `freq_q` from the first byte and `width_q` from the second byte. `ctrl_q` keeps its value.
- R5: A frame of exactly 8 bits loads only `width_q`. `ctrl_q` and `freq_q` keep their values.
- R6: A frame with any other bit count is discarded. This covers 0 bits, counts that are not a multiple of 8, and more than 24 bits. No register changes and `wr_pulse` stays 0.
- R7: `init_done` stays 0 until the first accepted 24-bit frame commits. After that it stays 1 until reset.
- R8: For an accepted frame, the registers change and `wr_pulse` is 1 for exactly one cycle. This happens on the fourth rising `clk` edge after `sel_n` rises at the pin.
- R9: No register changes while a frame is being shifted in.
- R10: `sclk` edges while `sel_n` is high cause no register change and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low port select (asynchronous) |
| sclk | input | 1 | Serial clock, idles low (asynchronous) |
| sdata | input | 1 | Serial data, taken on rising `sclk` |
| ctrl_q | output | 8 | Control register |
| freq_q | output | 8 | Frequency register |
| width_q | output | 8 | Pulse-width register |
| init_done | output | 1 | Set by the first full 24-bit load |
| wr_pulse | output | 1 | One-cycle strobe on any register update |

## Verification
The assertions assume that the serial clock runs at no more than a quarter of the system clock. They also assume that each serial-clock level lasts at least two system cycles, and that select never changes within two cycles of a serial-clock edge. Under these conditions no edge is lost or merged in the synchronizers. The stimulus holds every serial-clock level for four system cycles. It also waits four cycles between the last falling serial-clock edge and the release of select. The idle-low serial clock is kept throughout, even in the stretches that toggle it while the port is deselected.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } ld_state_t;

endpackage

// File: rtl/cfg_sync_bus.sv
module cfg_sync_bus #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) begin
                pipe_q[k] <= RST_VAL;
            end
        end else begin
            pipe_q[0] <= async_in;
            for (int k = 1; k < STAGES; k++) begin
                pipe_q[k] <= pipe_q[k-1];
            end
        end
    end

    assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_loader_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int CHAIN_W  = BYTE_W * NUM_BYTES,
    localparam int CNT_MAX  = CHAIN_W + 1,
    localparam int CNT_W    = $clog2(CNT_MAX + 1),
    localparam int NB_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n_s,
    input  logic               sclk_s,
    input  logic               sdata_s,
    output logic               busy,
    output logic               commit_en,
    output logic [NB_W-1:0]    nbytes,
    output logic [CHAIN_W-1:0] chain
);

    ld_state_t          state_q, state_d;
    logic               sel_prev_q, sclk_prev_q;
    logic               sel_fall, sel_rise, sclk_rise;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [CHAIN_W-1:0] chain_q;

    // edge detection in the system clock domain
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev_q  <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            sel_prev_q  <= sel_n_s;
            sclk_prev_q <= sclk_s;
        end
    end

    assign sel_fall  = sel_prev_q & ~sel_n_s;
    assign sel_rise  = ~sel_prev_q & sel_n_s;
    assign sclk_rise = ~sclk_prev_q & sclk_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sel_fall) state_d = ST_SHIFT;
            ST_SHIFT:  if (sel_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // shift chain and saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q   <= '0;
            bit_cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sel_fall) begin
                        chain_q   <= '0;
                        bit_cnt_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (sclk_rise && !sel_rise) begin
                        chain_q <= {chain_q[CHAIN_W-2:0], sdata_s};
                        if (bit_cnt_q != CNT_W'(CNT_MAX)) begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == ST_SHIFT);
        commit_en = (state_q == ST_COMMIT);
        chain     = chain_q;
        nbytes    = '0;
        for (int k = 1; k <= NUM_BYTES; k++) begin
            if (bit_cnt_q == CNT_W'(k * BYTE_W)) begin
                nbytes = NB_W'(k);
            end
        end
    end

    // R8
    commit_follows_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_rise) |=> commit_en);

    // R2
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && busy && !sel_rise && bit_cnt_q < CNT_W'(CNT_MAX)) |=> (bit_cnt_q == $past(bit_cnt_q) + 1'b1));

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int CHAIN_W  = BYTE_W * NUM_BYTES,
    localparam int NB_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit_en,
    input  logic [NB_W-1:0]    nbytes,
    input  logic [CHAIN_W-1:0] chain,
    output logic [CHAIN_W-1:0] bank,
    output logic               init_done,
    output logic               wr_pulse
);

    logic [BYTE_W-1:0] regs_q [NUM_BYTES];
    logic              init_q, pulse_q;

    // register j takes byte (NUM_BYTES-1-j) counted from the chain's low end;
    // it is written when the frame carried at least NUM_BYTES-j bytes
    for (genvar j = 0; j < NUM_BYTES; j++) begin : g_reg
        localparam int LSB  = (NUM_BYTES - 1 - j) * BYTE_W;
        localparam int NEED = NUM_BYTES - j;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[j] <= '0;
            end else if (commit_en && nbytes >= NB_W'(NEED)) begin
                regs_q[j] <= chain[LSB +: BYTE_W];
            end
        end

        assign bank[j*BYTE_W +: BYTE_W] = regs_q[j];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= commit_en && (nbytes != '0);
            if (commit_en && nbytes == NB_W'(NUM_BYTES)) begin
                init_q <= 1'b1;
            end
        end
    end

    assign init_done = init_q;
    assign wr_pulse  = pulse_q;

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R7
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6
    bad_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && nbytes == '0) |=> (!wr_pulse && $stable(bank)));

    // R5
    short_frame_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && nbytes != NB_W'(NUM_BYTES)) |=> $stable(regs_q[0]));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdata,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] freq_q,
    output logic [BYTE_W-1:0] width_q,
    output logic              init_done,
    output logic              wr_pulse
);

    localparam int NUM_BYTES = 3;
    localparam int CHAIN_W   = BYTE_W * NUM_BYTES;
    localparam int NB_W      = $clog2(NUM_BYTES + 1);

    logic [2:0]         pins_s;
    logic               busy, commit_en;
    logic [NB_W-1:0]    nbytes;
    logic [CHAIN_W-1:0] chain, bank;

    // pin order: {sel_n, sclk, sdata}; select resets to deselected
    cfg_sync_bus #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sel_n, sclk, sdata}),
        .sync_out (pins_s)
    );

    cfg_frame_fsm #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n_s   (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .sdata_s   (pins_s[0]),
        .busy      (busy),
        .commit_en (commit_en),
        .nbytes    (nbytes),
        .chain     (chain)
    );

    cfg_reg_bank #(
        .BYTE_W    (BYTE_W),
        .NUM_BYTES (NUM_BYTES)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_en (commit_en),
        .nbytes    (nbytes),
        .chain     (chain),
        .bank      (bank),
        .init_done (init_done),
        .wr_pulse  (wr_pulse)
    );

    assign ctrl_q  = bank[0*BYTE_W +: BYTE_W];
    assign freq_q  = bank[1*BYTE_W +: BYTE_W];
    assign width_q = bank[2*BYTE_W +: BYTE_W];

    // R9
    hold_while_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(bank));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !commit_en) |=> !wr_pulse);

endmodule

// File: tb/sim_serial_cfg_loader.sv
module sim_serial_cfg_loader;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int LATENCY    = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata = 1'b0;
    logic [7:0] ctrl_q, freq_q, width_q;
    logic       init_done, wr_pulse;

    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    // reference model state
    logic [7:0] m_ctrl = 0, m_freq = 0, m_width = 0;
    bit         m_init = 0;
    bit         pend = 0;
    int         pend_due = 0;
    int         pend_bits = 0;
    logic [31:0] pend_val = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_cfg_loader u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n),
        .sclk      (sclk),
        .sdata     (sdata),
        .ctrl_q    (ctrl_q),
        .freq_q    (freq_q),
        .width_q   (width_q),
        .init_done (init_done),
        .wr_pulse  (wr_pulse)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        bit exp_pulse;
        exp_pulse = 0;
        if (rst_n) begin
            if (pend && cyc == pend_due) begin
                pend = 0;
                unique case (pend_bits)
                    24: begin
                        m_ctrl  = pend_val[23:16];
                        m_freq  = pend_val[15:8];
                        m_width = pend_val[7:0];
                        m_init  = 1;
                        exp_pulse = 1;
                    end
                    16: begin
                        m_freq  = pend_val[15:8];
                        m_width = pend_val[7:0];
                        exp_pulse = 1;
                    end
                    8: begin
                        m_width = pend_val[7:0];
                        exp_pulse = 1;
                    end
                    default: exp_pulse = 0;
                endcase
            end
            chk(ctrl_q == m_ctrl, cur_tag, "ctrl_q", 32'(ctrl_q), 32'(m_ctrl));
            chk(freq_q == m_freq, cur_tag, "freq_q", 32'(freq_q), 32'(m_freq));
            chk(width_q == m_width, cur_tag, "width_q", 32'(width_q), 32'(m_width));
            chk(init_done == m_init, cur_tag, "init_done", 32'(init_done), 32'(m_init));
            chk(wr_pulse == exp_pulse, cur_tag, "wr_pulse R8", 32'(wr_pulse), 32'(exp_pulse));
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // send nbits of val, MSB first (R2)
    task automatic send_frame(input int nbits, input logic [31:0] val, input string tag);
        cur_tag = tag;
        @(negedge clk);
        sel_n = 1'b0;
        wait_clk(HALF_SCK);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdata = val[i];
            wait_clk(HALF_SCK);
            sclk = 1'b1;
            wait_clk(HALF_SCK);
            sclk = 1'b0;
        end
        wait_clk(HALF_SCK);
        sel_n    = 1'b1;
        pend_bits = nbits;
        pend_val  = val;
        pend_due  = cyc + LATENCY;
        pend      = 1;
        wait_clk(3 * HALF_SCK);
    endtask

    initial begin
        wait_clk(3);
        // R1: reset state
        chk(ctrl_q == 0 && freq_q == 0 && width_q == 0, "R1", "regs in reset",
            {8'h0, ctrl_q, freq_q, width_q}, 32'h0);
        chk(!init_done && !wr_pulse, "R1", "flags in reset",
            {30'h0, init_done, wr_pulse}, 32'h0);
        rst_n = 1'b1;
        wait_clk(4);

        send_frame(8, 32'h0000_00A5, "R5");     // width only, init stays 0 (R7)
        send_frame(16, 32'h0000_3C5A, "R4");    // freq then width
        chk(init_done == 0, "R7", "init before full frame", 32'(init_done), 32'h0);
        send_frame(24, 32'h0081_42C3, "R3");    // ctrl, freq, width; R2 order
        chk(init_done == 1, "R7", "init after full frame", 32'(init_done), 32'h1);
        send_frame(8, 32'h0000_000F, "R5");
        send_frame(12, 32'h0000_0ABC, "R6");    // not a multiple of 8
        send_frame(0, 32'h0, "R6");             // empty frame
        send_frame(30, 32'h3FFF_FFFF, "R6");    // too long
        send_frame(23, 32'h007F_FFFF, "R6");

        // R10: serial clock toggling while deselected
        cur_tag = "R10";
        for (int i = 0; i < 10; i++) begin
            sdata = i[0];
            wait_clk(HALF_SCK);
            sclk = 1'b1;
            wait_clk(HALF_SCK);
            sclk = 1'b0;
        end
        wait_clk(8);

        send_frame(24, 32'h0012_3456, "R9");    // regs held until release, init sticky
        send_frame(16, 32'h0000_E718, "R4");
        send_frame(8, 32'h0000_0001, "R2");     // single low bit lands in bit 0
        send_frame(24, 32'h00FF_00FF, "R3");
        chk(init_done == 1, "R7", "init sticky", 32'(init_done), 32'h1);
        wait_clk(10);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule